// File: doc/BRIEF.md
# Text Command Decoder for a 16-bit Register Bus

This block sits behind a serial byte receiver and turns short printable text lines into register transactions. A host sends a line that starts with a letter selecting read or write. The letter is followed by hexadecimal digits for the address and, for a write, for the data, and the line closes with carriage return and line feed. Once the closing byte has arrived and the whole line matched the expected shape, the block raises a one-clock request carrying the address, the data and a direction flag. The register file and the reply path act on that request.

Any line that breaks the expected shape is thrown away without a trace, and the decoder goes back to waiting for a command letter. A read request only tells the reply path that a read is pending. The reply line is built elsewhere: the letter 'D', four hex digits and CR LF.

Byte input uses a valid/ready pair. The decoder takes one byte in every clock and never applies back-pressure, so `in_ready_o` stays high. A byte counts only on a rising edge where `in_valid_i` is high, and the source may leave any number of idle cycles between bytes. The request output has no ready: the consumer must act on the cycle in which `valid_o` is high.

Top module: `hex_cmd_parser`

## Requirements
- R1: The line 'R' (0x52), four hex digits, CR (0x0D), LF (0x0A) produces a request with rw_o = 0, addr_o = the digits, and data_o = 0.
- R2: The line 'W' (0x57), four address digits, four data digits, CR, LF produces a request with rw_o = 1, addr_o and data_o taken from the digits.
- R3: Each field is 16 bits, and its first digit is the most significant nibble.
- R4: The hex digits accepted are '0'-'9' (0x30-0x39) for 0-9, and both 'A'-'F' (0x41-0x46) and 'a'-'f' (0x61-0x66) for 10-15. Every other byte in a digit position, including 0x2F, 0x3A, 0x40, 0x47, 0x60 and 0x67, is not a digit.
- R5: A bad line produces no request. A bad line is one with an unknown first letter, a non-digit in a digit position, too few or too many digits, or a missing CR or LF. The offending byte is consumed, and the next well-formed line is decoded normally.
- R6: valid_o is high for exactly one clock. That clock is the one right after the rising edge that accepted the closing LF.
- R7: addr_o, data_o and rw_o hold their values from one request until the next, including across bad lines.
- R8: Lines may follow one another with no idle cycle. The command letter accepted on the edge right after the LF starts a new line.
- R9: A synchronous active-high reset discards any partial line and clears valid_o, rw_o, addr_o and data_o to 0. Bytes that complete the interrupted line after reset produce no request.
- R10: in_ready_o is always 1. Cycles with in_valid_i low do not advance the decoder, so a line spread over idle gaps decodes the same as a packed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Input byte present |
| in_data_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Byte acceptance, always high |
| valid_o | output | 1 | One-clock request strobe |
| rw_o | output | 1 | 1 = write, 0 = read |
| addr_o | output | 16 | Request address |
| data_o | output | 16 | Write data (0 for a read) |

## Verification
Two functions can fall in the same cycle: the request pulse for a finished line, and the acceptance of the next line's command letter. They coincide whenever lines are streamed with no idle byte between them. The bench provokes this by sending three lines back to back. It then judges the result by the number of pulses and by the address, data and direction it captured at each pulse, which must show that the letter arriving during a pulse was neither lost nor allowed to disturb that pulse's fields.

// File: rtl/hcp_pkg.sv
package hcp_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CH_READ  = 8'h52;
  localparam logic [BYTE_W-1:0] CH_WRITE = 8'h57;
  localparam logic [BYTE_W-1:0] CH_CR    = 8'h0D;
  localparam logic [BYTE_W-1:0] CH_LF    = 8'h0A;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_CR,
    ST_LF
  } hcp_state_e;

endpackage

// File: rtl/hcp_hex_digit.sv
module hcp_hex_digit
  import hcp_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output logic              is_hex_o,
  output logic [3:0]        nib_o
);

  logic is_num;
  logic is_upper;
  logic is_lower;

  always_comb begin
    is_num   = (byte_i >= 8'h30) && (byte_i <= 8'h39);
    is_upper = (byte_i >= 8'h41) && (byte_i <= 8'h46);
    is_lower = (byte_i >= 8'h61) && (byte_i <= 8'h66);
    is_hex_o = is_num | is_upper | is_lower;
    if (is_num)
      nib_o = byte_i[3:0];
    else if (is_upper | is_lower)
      nib_o = 4'd9 + byte_i[3:0];
    else
      nib_o = 4'd0;
  end

endmodule

// File: rtl/hcp_nibble_shift.sv
module hcp_nibble_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic [3:0]   nib_i,
  output logic [W-1:0] value_o
);

  logic [W-1:0] value_q;

  generate
    if (W > 4) begin : g_wide
      always_ff @(posedge clk) begin
        if (rst || clr_i)
          value_q <= '0;
        else if (shift_i)
          value_q <= {value_q[W-5:0], nib_i};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst || clr_i)
          value_q <= '0;
        else if (shift_i)
          value_q <= nib_i[W-1:0];
      end
    end
  endgenerate

  assign value_o = value_q;

endmodule

// File: rtl/hcp_frame_ctrl.sv
module hcp_frame_ctrl
  import hcp_pkg::*;
#(
  parameter int ADDR_DIGITS = 4,
  parameter int DATA_DIGITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              is_hex_i,
  output logic              clr_o,
  output logic              shift_addr_o,
  output logic              shift_data_o,
  output logic              done_o,
  output logic              is_write_o
);

  localparam int MAX_DIGITS = (ADDR_DIGITS > DATA_DIGITS) ? ADDR_DIGITS : DATA_DIGITS;
  localparam int CNT_W      = (MAX_DIGITS > 1) ? $clog2(MAX_DIGITS) : 1;
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_DIGITS - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_DIGITS - 1);

  hcp_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_q;
  logic             is_cmd;

  assign is_cmd = (byte_i == CH_READ) || (byte_i == CH_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
    end else if (take_i) begin
      case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (is_cmd) begin
            state_q <= ST_ADDR;
            wr_q    <= (byte_i == CH_WRITE);
          end
        end
        ST_ADDR: begin
          if (!is_hex_i) begin
            state_q <= ST_IDLE;
          end else if (cnt_q == ADDR_LAST) begin
            cnt_q   <= '0;
            state_q <= wr_q ? ST_DATA : ST_CR;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (!is_hex_i) begin
            state_q <= ST_IDLE;
          end else if (cnt_q == DATA_LAST) begin
            cnt_q   <= '0;
            state_q <= ST_CR;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_CR:   state_q <= (byte_i == CH_CR) ? ST_LF : ST_IDLE;
        ST_LF:   state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    clr_o        = take_i && (state_q == ST_IDLE) && is_cmd;
    shift_addr_o = take_i && (state_q == ST_ADDR) && is_hex_i;
    shift_data_o = take_i && (state_q == ST_DATA) && is_hex_i;
    done_o       = take_i && (state_q == ST_LF) && (byte_i == CH_LF);
    is_write_o   = wr_q;
  end

endmodule

// File: rtl/hex_cmd_parser.sv
module hex_cmd_parser
  import hcp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              valid_o,
  output logic              rw_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int ADDR_DIGITS = ADDR_W / 4;
  localparam int DATA_DIGITS = DATA_W / 4;

  logic              take;
  logic              is_hex;
  logic [3:0]        nib;
  logic              clr;
  logic              shift_addr;
  logic              shift_data;
  logic              done;
  logic              is_write;
  logic [ADDR_W-1:0] addr_acc;
  logic [DATA_W-1:0] data_acc;

  assign in_ready_o = 1'b1;
  assign take       = in_valid_i & in_ready_o;

  hcp_hex_digit u_digit (
    .byte_i   (in_data_i),
    .is_hex_o (is_hex),
    .nib_o    (nib)
  );

  hcp_frame_ctrl #(
    .ADDR_DIGITS (ADDR_DIGITS),
    .DATA_DIGITS (DATA_DIGITS)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .take_i       (take),
    .byte_i       (in_data_i),
    .is_hex_i     (is_hex),
    .clr_o        (clr),
    .shift_addr_o (shift_addr),
    .shift_data_o (shift_data),
    .done_o       (done),
    .is_write_o   (is_write)
  );

  hcp_nibble_shift #(.W(ADDR_W)) u_addr_sh (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (clr),
    .shift_i (shift_addr),
    .nib_i   (nib),
    .value_o (addr_acc)
  );

  hcp_nibble_shift #(.W(DATA_W)) u_data_sh (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (clr),
    .shift_i (shift_data),
    .nib_i   (nib),
    .value_o (data_acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      rw_o    <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else begin
      valid_o <= done;
      if (done) begin
        rw_o   <= is_write;
        addr_o <= addr_acc;
        data_o <= is_write ? data_acc : '0;
      end
    end
  end

endmodule

// File: rtl/hcp_checker.sv
module hcp_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid_i,
  input logic [7:0]        in_data_i,
  input logic              valid_o,
  input logic              rw_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [DATA_W-1:0] data_o
);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R6

  AST_PULSE_AFTER_LF: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ($past(in_valid_i) && ($past(in_data_i) == 8'h0A))); // R6

  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (rst)
    (!valid_o && !$past(rst)) |-> ($stable(addr_o) && $stable(data_o) && $stable(rw_o))); // R7

  AST_READ_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !rw_o) |-> (data_o == '0)); // R1

  always @(negedge clk) begin
    if (rst_q)
      AST_RESET_CLEAR: assert (!valid_o && !rw_o && addr_o == '0 && data_o == '0); // R9
  end

endmodule

bind hex_cmd_parser hcp_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_hcp_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid_i (in_valid_i),
  .in_data_i  (in_data_i),
  .valid_o    (valid_o),
  .rw_o       (rw_o),
  .addr_o     (addr_o),
  .data_o     (data_o)
);

// File: tb/tb_hex_cmd_parser.sv
module tb_hex_cmd_parser;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid_i = 1'b0;
  logic [7:0]  in_data_i = 8'h00;
  logic        in_ready_o;
  logic        valid_o;
  logic        rw_o;
  logic [15:0] addr_o;
  logic [15:0] data_o;

  always #5 clk = ~clk;

  hex_cmd_parser dut (
    .clk        (clk),
    .rst        (rst),
    .in_valid_i (in_valid_i),
    .in_data_i  (in_data_i),
    .in_ready_o (in_ready_o),
    .valid_o    (valid_o),
    .rw_o       (rw_o),
    .addr_o     (addr_o),
    .data_o     (data_o)
  );

  typedef struct packed {
    logic [95:0] txt;
    logic [7:0]  len;
    logic        pulse;
    logic        rw;
    logic [15:0] addr;
    logic [15:0] data;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{96'("R12AB\r\n"),     8'd7,  1'b1, 1'b0, 16'h12AB, 16'h0000},
    '{96'("W0000FFFF\r\n"), 8'd11, 1'b1, 1'b1, 16'h0000, 16'hFFFF},
    '{96'("Wbeef1a2C\r\n"), 8'd11, 1'b1, 1'b1, 16'hBEEF, 16'h1A2C},
    '{96'("RFfA9\r\n"),     8'd7,  1'b1, 1'b0, 16'hFFA9, 16'h0000},
    '{96'("R12G4\r\n"),     8'd7,  1'b0, 1'b0, 16'h0, 16'h0},
    '{96'("X1234\r\n"),     8'd7,  1'b0, 1'b0, 16'h0, 16'h0},
    '{96'("R123\r\n"),      8'd6,  1'b0, 1'b0, 16'h0, 16'h0},
    '{96'("R12345\r\n"),    8'd8,  1'b0, 1'b0, 16'h0, 16'h0},
    '{96'("R1234\n"),       8'd6,  1'b0, 1'b0, 16'h0, 16'h0},
    '{96'("R1234\r\r"),     8'd7,  1'b0, 1'b0, 16'h0, 16'h0},
    '{96'("R0:00\r\n"),     8'd7,  1'b0, 1'b0, 16'h0, 16'h0},
    '{96'("R/000\r\n"),     8'd7,  1'b0, 1'b0, 16'h0, 16'h0},
    '{96'("R@000\r\n"),     8'd7,  1'b0, 1'b0, 16'h0, 16'h0},
    '{96'("R`000\r\n"),     8'd7,  1'b0, 1'b0, 16'h0, 16'h0},
    '{96'("R000g\r\n"),     8'd7,  1'b0, 1'b0, 16'h0, 16'h0},
    '{96'("W1234567\r\n"),  8'd10, 1'b0, 1'b0, 16'h0, 16'h0},
    '{96'("W12345678\r\n"), 8'd11, 1'b1, 1'b1, 16'h1234, 16'h5678}
  };

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  int wide = 0;
  logic        prev_v = 1'b0;
  logic [15:0] hist_a [8];
  logic [15:0] hist_d [8];
  logic        hist_rw [8];
  logic        done = 1'b0;

  always @(negedge clk) begin
    if (valid_o) begin
      hist_a[pulses % 8]  = addr_o;
      hist_d[pulses % 8]  = data_o;
      hist_rw[pulses % 8] = rw_o;
      pulses++;
      if (prev_v) wide++;
    end
    prev_v = valid_o;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid_i = 1'b1;
    in_data_i  = b;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid_i = 1'b0;
      in_data_i  = 8'h00;
    end
  endtask

  task automatic send_text(input logic [95:0] txt, input int len, input int gap);
    for (int i = 0; i < len; i++) begin
      send_byte(txt[8*(len-1-i) +: 8]);
      if (gap > 0) idle(gap);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [15:0] last_a;
    logic [15:0] last_d;
    logic        last_rw;
    int          p0;

    repeat (3) @(negedge clk);
    // R9: reset state; R10: ready high
    check("R9 valid at reset", {31'd0, valid_o}, 32'd0);
    check("R9 addr at reset", {16'd0, addr_o}, 32'd0);
    check("R9 data at reset", {16'd0, data_o}, 32'd0);
    check("R10 ready", {31'd0, in_ready_o}, 32'd1);
    rst = 1'b0;
    last_a = 16'h0; last_d = 16'h0; last_rw = 1'b0;

    for (int v = 0; v < NV; v++) begin
      p0 = pulses;
      send_text(VECS[v].txt, int'(VECS[v].len), 0);
      idle(3);
      if (VECS[v].pulse) begin
        check(VECS[v].rw ? "R2 pulse count" : "R1 pulse count", pulses - p0, 32'd1);
        check("R3 R4 addr", {16'd0, addr_o}, {16'd0, VECS[v].addr});
        check(VECS[v].rw ? "R2 data" : "R1 data", {16'd0, data_o}, {16'd0, VECS[v].data});
        check(VECS[v].rw ? "R2 rw" : "R1 rw", {31'd0, rw_o}, {31'd0, VECS[v].rw});
        last_a = VECS[v].addr; last_d = VECS[v].data; last_rw = VECS[v].rw;
      end else begin
        check("R5 no pulse", pulses - p0, 32'd0);
        check("R7 addr held", {16'd0, addr_o}, {16'd0, last_a});
        check("R7 data held", {16'd0, data_o}, {16'd0, last_d});
        check("R7 rw held", {31'd0, rw_o}, {31'd0, last_rw});
      end
    end

    // R6: pulse appears in the cycle after LF acceptance, lasts one clock
    send_text(96'("R0F0F"), 5, 0);
    send_byte(8'h0D);
    send_byte(8'h0A);
    idle(1);
    check("R6 pulse after LF", {31'd0, valid_o}, 32'd1);
    idle(1);
    check("R6 pulse ended", {31'd0, valid_o}, 32'd0);
    check("R6 no wide pulse", wide, 32'd0);

    // R8: three lines back to back
    p0 = pulses;
    send_text(96'("R1111\r\n"), 7, 0);
    send_text(96'("W22223333\r\n"), 11, 0);
    send_text(96'("R4444\r\n"), 7, 0);
    idle(3);
    check("R8 pulse count", pulses - p0, 32'd3);
    check("R8 first addr", {16'd0, hist_a[p0 % 8]}, 32'h1111);
    check("R8 second addr", {16'd0, hist_a[(p0+1) % 8]}, 32'h2222);
    check("R8 second data", {16'd0, hist_d[(p0+1) % 8]}, 32'h3333);
    check("R8 second rw", {31'd0, hist_rw[(p0+1) % 8]}, 32'd1);
    check("R8 third addr", {16'd0, hist_a[(p0+2) % 8]}, 32'h4444);
    check("R8 third rw", {31'd0, hist_rw[(p0+2) % 8]}, 32'd0);

    // R10: idle gaps between every byte
    p0 = pulses;
    send_text(96'("WA55A0F0F\r\n"), 11, 2);
    idle(3);
    check("R10 gapped pulse", pulses - p0, 32'd1);
    check("R10 gapped addr", {16'd0, addr_o}, 32'hA55A);
    check("R10 gapped data", {16'd0, data_o}, 32'h0F0F);

    // R9: reset in mid-line discards the partial line
    p0 = pulses;
    send_text(96'("W1234"), 5, 0);
    @(negedge clk);
    in_valid_i = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R9 addr cleared", {16'd0, addr_o}, 32'd0);
    check("R9 data cleared", {16'd0, data_o}, 32'd0);
    check("R9 rw cleared", {31'd0, rw_o}, 32'd0);
    rst = 1'b0;
    send_text(96'("5678\r\n"), 6, 0);
    idle(3);
    check("R9 no pulse after reset", pulses - p0, 32'd0);
    check("R9 outputs still clear", {16'd0, addr_o}, 32'd0);

    done = 1'b1;
    finish_run();
  end

endmodule